// File: doc/BRIEF.md
# Radix-8 Signed-Digit Divider Datapath

This block divides one normalized fraction by another, three quotient bits per clock. Both operands are unsigned fractions in [0.5, 1), so the most significant bit of each is set. A start pulse captures the operands. A loop then refines a partial remainder, kept in carry-save form, and on every step emits one signed quotient digit in the range -7..7. A downstream converter assembles these digits into a binary quotient. After the last step, one further cycle adds the two halves of the final remainder and reports its sign and whether it is zero. The converter uses these two flags for correction and rounding.

Each digit leaves the block as two parts. A coarse part has weight 4 and a fine part has weight 1, and each part is in -2..2. Each part is carried on four lines with at most one line active, so the divisor multiples inside the loop come from plain shifts and inversions. The loop has no dividend multiplexer. On the capture edge the digit registers are preset to coarse 0 and fine -1 and the remainder is cleared, so the first pass of the ordinary update writes the dividend, scaled by 1/8, as the initial remainder. The operand width is a parameter, and the digit count and internal widths follow from it.

Top module: `r8_digit_div`

## Requirements
- R1: A start pulse seen on a rising edge while the block is idle captures `dividend` and `divisor`. Later changes on those inputs have no effect on the operation in progress.
- R2: The block delivers exactly N = (OP_W+3)/3 digits, with `digit_valid` high on the 1st through Nth rising edges after the accepting edge and low at every other time.
- R3: `digit_hi` and `digit_lo` are each zero or one-hot. Bit 3 means +2, bit 2 means +1, bit 1 means -1, bit 0 means -2, and all-zero means 0. The digit is 4·hi + lo.
- R4: With X and D the operands read as integers and Q = Σ q_i·8^(N-i) the accumulated digits, the remainder R = X·8^(N-1) - Q·D satisfies -D ≤ R ≤ D.
- R5: Q - (1 if R < 0, else 0) equals floor(X·8^(N-1) / D).
- R6: When `done` is high, `rem_neg` is 1 exactly when R < 0 and `rem_zero` is 1 exactly when R = 0. `rem_zero` never accompanies `rem_neg`.
- R7: `done` is a single-cycle pulse on the (N+2)th rising edge after the accepting edge. `rem_neg` and `rem_zero` change only on that edge and hold afterwards.
- R8: A start pulse during an operation is ignored: that operation's digits, flags and timing are unchanged.
- R9: After reset, `done` and `digit_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division when idle |
| dividend | input | OP_W | Dividend fraction in [0.5, 1), MSB set |
| divisor | input | OP_W | Divisor fraction in [0.5, 1), MSB set |
| digit_valid | output | 1 | A quotient digit is present this cycle |
| digit_hi | output | 4 | Weight-4 part of the digit, one-hot or zero |
| digit_lo | output | 4 | Weight-1 part of the digit, one-hot or zero |
| rem_neg | output | 1 | Final remainder is negative |
| rem_zero | output | 1 | Final remainder is zero |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with OP_W = 53. This gives 18 digits per division, a 58-bit carry-save remainder, and a 20-cycle operation, so exact 128-bit integer arithmetic in the bench can form X·8^17 and the implied remainder. At this width, random divisors reach all eight divisor-index intervals of the digit selection. The directed cases add the operand extremes: equal operands, minimum over maximum, maximum over minimum, and exactly divisible pairs. Each division also changes the operand inputs after capture, and some divisions pulse start mid-operation, so capture and busy behaviour are checked at the ports.

// File: rtl/r8div_pkg.sv
package r8div_pkg;

    // Remainder estimate used for digit choice: 2 integer + 7 fractional bits
    // of the stored residual, i.e. 8*w in units of 1/16.
    localparam int EST_INT  = 2;
    localparam int EST_FRAC = 7;
    localparam int EST_W    = EST_INT + EST_FRAC;
    // Divisor bits after the leading one that index the threshold set.
    localparam int DIDX_W   = 3;
    localparam int DIG_MAX  = 7;

    // One half of a quotient digit: at most one line set, none set means 0.
    typedef struct packed {
        logic pos2;
        logic pos1;
        logic neg1;
        logic neg2;
    } half_digit_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ITER  = 2'd1,
        ST_ROUND = 2'd2
    } phase_t;

    function automatic half_digit_t enc_half(input int v);
        half_digit_t h;
        h = '0;
        case (v)
            2:       h.pos2 = 1'b1;
            1:       h.pos1 = 1'b1;
            -1:      h.neg1 = 1'b1;
            -2:      h.neg2 = 1'b1;
            default: h = '0;
        endcase
        return h;
    endfunction

    // Lower bound (units of 1/16) of the estimate for choosing digit k,
    // for the divisor interval [(8+idx)/16, (9+idx)/16).
    function automatic int sel_threshold(input int k, input int idx);
        if (k >= 1)
            return (k - 1) * (9 + idx);
        else
            return (k - 1) * (8 + idx);
    endfunction

endpackage

// File: rtl/r8div_select.sv
module r8div_select
    import r8div_pkg::*;
(
    input  logic [EST_W-1:0]  est_sum,
    input  logic [EST_W-1:0]  est_car,
    input  logic [DIDX_W-1:0] d_idx,
    output half_digit_t       q_hi,
    output half_digit_t       q_lo
);
    logic signed [EST_W-1:0] y_est;
    int q_val;
    int hi_val;
    int lo_val;

    // Assimilate the truncated carry-save top bits (always rounds down).
    assign y_est = est_sum + est_car;

    always_comb begin
        q_val = -DIG_MAX;
        for (int k = -DIG_MAX + 1; k <= DIG_MAX; k++) begin
            if (int'(y_est) >= sel_threshold(k, int'(d_idx)))
                q_val = q_val + 1;
        end
        // Split q = 4*hi + lo with both parts in -2..2.
        hi_val = (q_val + 2) >>> 2;
        lo_val = q_val - 4 * hi_val;
        q_hi   = enc_half(hi_val);
        q_lo   = enc_half(lo_val);
    end

endmodule

// File: rtl/r8div_recur.sv
module r8div_recur
    import r8div_pkg::*;
#(
    parameter int W = 58
) (
    input  logic [W-4:0]  ws_lo,
    input  logic [W-4:0]  wc_lo,
    input  logic [W-1:0]  base,
    input  half_digit_t   q_hi,
    input  half_digit_t   q_lo,
    output logic [W-1:0]  ws_n,
    output logic [W-1:0]  wc_n
);
    logic [W-1:0] sh_s, sh_c;
    logic [W-1:0] mag_h, mag_l, add_h, add_l;
    logic         neg_h, neg_l;
    logic [W-1:0] s1, c1s, s2;
    logic [W-2:0] c1, c2;

    // 8*w by wiring; bits shifted out are redundant modulo 2^W.
    assign sh_s = {ws_lo, 3'b000};
    assign sh_c = {wc_lo, 3'b000};

    always_comb begin
        mag_h = '0;
        if (q_hi.pos2 | q_hi.neg2)      mag_h = {base[W-4:0], 3'b000};
        else if (q_hi.pos1 | q_hi.neg1) mag_h = {base[W-3:0], 2'b00};
        neg_h = q_hi.pos1 | q_hi.pos2;
        add_h = neg_h ? ~mag_h : mag_h;

        mag_l = '0;
        if (q_lo.pos2 | q_lo.neg2)      mag_l = {base[W-2:0], 1'b0};
        else if (q_lo.pos1 | q_lo.neg1) mag_l = base;
        neg_l = q_lo.pos1 | q_lo.pos2;
        add_l = neg_l ? ~mag_l : mag_l;
    end

    // Two 3:2 levels; the +1 of each two's complement enters a free carry LSB.
    assign s1  = sh_s ^ sh_c ^ add_h;
    assign c1  = (sh_s[W-2:0] & sh_c[W-2:0]) | (sh_s[W-2:0] & add_h[W-2:0])
               | (sh_c[W-2:0] & add_h[W-2:0]);
    assign c1s = {c1, neg_h};

    assign s2  = s1 ^ c1s ^ add_l;
    assign c2  = (s1[W-2:0] & c1s[W-2:0]) | (s1[W-2:0] & add_l[W-2:0])
               | (c1s[W-2:0] & add_l[W-2:0]);

    assign ws_n = s2;
    assign wc_n = {c2, neg_l};

endmodule

// File: rtl/r8div_signzero.sv
module r8div_signzero #(
    parameter int W = 58
) (
    input  logic         en,
    input  logic [W-1:0] ws,
    input  logic [W-1:0] wc,
    output logic         neg,
    output logic         zero
);
    logic [W-1:0] gs, gc, tot;

    // Inputs forced low outside the rounding cycle to keep the adder quiet.
    assign gs   = en ? ws : '0;
    assign gc   = en ? wc : '0;
    assign tot  = gs + gc;
    assign neg  = tot[W-1];
    assign zero = (tot == '0);

endmodule

// File: rtl/r8div_ctrl.sv
module r8div_ctrl
    import r8div_pkg::*;
#(
    parameter int NDIG  = 18,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output phase_t           phase,
    output logic             accept,
    output logic             step,
    output logic             load,
    output logic             round,
    output logic             digit_valid,
    output logic             done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NDIG);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= ST_IDLE;
            cnt   <= '0;
            load  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                ST_IDLE: begin
                    if (start) begin
                        phase <= ST_ITER;
                        cnt   <= '0;
                        load  <= 1'b1;
                    end
                end
                ST_ITER: begin
                    load <= 1'b0;
                    cnt  <= cnt + 1'b1;
                    if (cnt == LAST) phase <= ST_ROUND;
                end
                ST_ROUND: begin
                    phase <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end

    assign accept      = (phase == ST_IDLE) && start;
    assign step        = (phase == ST_ITER);
    assign round       = (phase == ST_ROUND);
    assign digit_valid = step && (cnt != '0);

    // R2: the counter never runs past the last iteration
    assert_count_range_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_ITER) |-> (cnt <= LAST));

    // R2: digits come back to back until the rounding cycle
    assert_digits_contiguous_R2: assert property (@(posedge clk) disable iff (rst)
        digit_valid |=> (digit_valid || phase == ST_ROUND));

    // R7: completion lasts one cycle and follows the rounding cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/r8_digit_div.sv
module r8_digit_div
    import r8div_pkg::*;
#(
    parameter int OP_W = 53
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [OP_W-1:0] dividend,
    input  logic [OP_W-1:0] divisor,
    output logic            digit_valid,
    output logic [3:0]      digit_hi,
    output logic [3:0]      digit_lo,
    output logic            rem_neg,
    output logic            rem_zero,
    output logic            done
);
    localparam int FRAC_W = OP_W + 3;
    localparam int W      = FRAC_W + 2;
    localparam int NDIG   = (OP_W + 3) / 3;
    localparam int CNT_W  = $clog2(NDIG + 1);

    phase_t       phase;
    logic         accept, step, load, round;
    logic [OP_W-1:0] dividend_q, divisor_q;
    logic [W-1:0] ws_q, wc_q, ws_n, wc_n;
    logic [W-1:0] x_frame, d_frame, base;
    half_digit_t  qh_q, ql_q, qh_n, ql_n;
    logic         sz_neg, sz_zero;
    logic         neg_q, zero_q;

    r8div_ctrl #(.NDIG(NDIG), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .phase       (phase),
        .accept      (accept),
        .step        (step),
        .load        (load),
        .round       (round),
        .digit_valid (digit_valid),
        .done        (done)
    );

    // Dividend enters pre-scaled by 1/8; divisor aligned to the residual frame.
    assign x_frame = {{(W-OP_W){1'b0}}, dividend_q};
    assign d_frame = {{(W-OP_W-3){1'b0}}, divisor_q, 3'b000};
    assign base    = load ? x_frame : d_frame;

    r8div_recur #(.W(W)) u_recur (
        .ws_lo (ws_q[W-4:0]),
        .wc_lo (wc_q[W-4:0]),
        .base  (base),
        .q_hi  (qh_q),
        .q_lo  (ql_q),
        .ws_n  (ws_n),
        .wc_n  (wc_n)
    );

    r8div_select u_select (
        .est_sum (ws_n[W-1 -: EST_W]),
        .est_car (wc_n[W-1 -: EST_W]),
        .d_idx   (divisor_q[OP_W-2 -: DIDX_W]),
        .q_hi    (qh_n),
        .q_lo    (ql_n)
    );

    r8div_signzero #(.W(W)) u_signzero (
        .en   (round),
        .ws   (ws_q),
        .wc   (wc_q),
        .neg  (sz_neg),
        .zero (sz_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dividend_q <= '0;
            divisor_q  <= '0;
            ws_q       <= '0;
            wc_q       <= '0;
            qh_q       <= '0;
            ql_q       <= '0;
            neg_q      <= 1'b0;
            zero_q     <= 1'b0;
        end else begin
            if (accept) begin
                dividend_q <= dividend;
                divisor_q  <= divisor;
                ws_q       <= '0;
                wc_q       <= '0;
                qh_q       <= enc_half(0);
                ql_q       <= enc_half(-1);
            end else if (step) begin
                ws_q <= ws_n;
                wc_q <= wc_n;
                qh_q <= qh_n;
                ql_q <= ql_n;
            end
            if (round) begin
                neg_q  <= sz_neg;
                zero_q <= sz_zero;
            end
        end
    end

    assign digit_hi = qh_q;
    assign digit_lo = ql_q;
    assign rem_neg  = neg_q;
    assign rem_zero = zero_q;

    // Residual magnitude, for the bound check only.
    logic signed [W-1:0] res_now;
    logic [W-1:0]        res_mag;
    assign res_now = ws_q + wc_q;
    assign res_mag = res_now[W-1] ? W'(-res_now) : W'(res_now);

    // R3: each half-digit register holds at most one active line
    assert_digit_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(qh_q) && $onehot0(ql_q));

    // R4: the stored residual never exceeds the divisor in magnitude
    assert_residual_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (phase != ST_IDLE && !load) |-> (res_mag <= d_frame));

    // R5: capture presets the digit registers so the first pass loads x
    assert_load_preset_R5: assert property (@(posedge clk) disable iff (rst)
        accept |=> (qh_q == enc_half(0) && ql_q == enc_half(-1)));

    // R6: a zero remainder is never flagged negative
    assert_zero_not_neg_R6: assert property (@(posedge clk) disable iff (rst)
        rem_zero |-> !rem_neg);

    // R7: flags move only on the edge leaving the rounding cycle
    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (phase != ST_ROUND) |=> ($stable(rem_neg) && $stable(rem_zero)));

    // R8: a start during an operation leaves the captured divisor alone
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_ITER) |=> $stable(divisor_q));

endmodule

// File: tb/test_r8_digit_div.sv
module test_r8_digit_div;
    localparam int CLK_PERIOD = 10;
    localparam int OP_W       = 53;
    localparam int NDIG       = (OP_W + 3) / 3;
    localparam int LAT        = NDIG + 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [OP_W-1:0] dividend = '0;
    logic [OP_W-1:0] divisor = '0;
    logic            digit_valid;
    logic [3:0]      digit_hi, digit_lo;
    logic            rem_neg, rem_zero, done;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    r8_digit_div #(.OP_W(OP_W)) i_r8_digit_div (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .dividend    (dividend),
        .divisor     (divisor),
        .digit_valid (digit_valid),
        .digit_hi    (digit_hi),
        .digit_lo    (digit_lo),
        .rem_neg     (rem_neg),
        .rem_zero    (rem_zero),
        .done        (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic signed [127:0] act, input logic signed [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Half-digit code per R3: bit3 +2, bit2 +1, bit1 -1, bit0 -2; 99 marks an illegal code.
    function automatic int dec_half(input logic [3:0] c);
        case (c)
            4'b0000: return 0;
            4'b1000: return 2;
            4'b0100: return 1;
            4'b0010: return -1;
            4'b0001: return -2;
            default: return 99;
        endcase
    endfunction

    function automatic logic [OP_W-1:0] rand_norm();
        return {1'b1, 20'($urandom), 32'($urandom)};
    endfunction

    task automatic run_div(input logic [OP_W-1:0] xv, input logic [OP_W-1:0] dv, input bit poke);
        logic signed [127:0] qacc, xbig, dbig, rem, qfloor, qcorr;
        int  ndig, first_k, last_k, done_k, bad;
        bit  saved_neg, saved_zero;
        qacc = 0; ndig = 0; first_k = -1; last_k = -1; done_k = -1; bad = 0;
        @(negedge clk);
        dividend = xv; divisor = dv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R1: scramble operand inputs after capture
        dividend = {21'($urandom), 32'($urandom)};
        divisor  = {21'($urandom), 32'($urandom)};
        for (int k = 1; k <= LAT + 4; k++) begin
            @(negedge clk);
            if (poke && k == 5) begin
                start = 1'b1;
                dividend = rand_norm();
                divisor  = rand_norm();
            end
            if (poke && k == 6) start = 1'b0;
            if (digit_valid) begin
                int h, l;
                h = dec_half(digit_hi);
                l = dec_half(digit_lo);
                if (h == 99 || l == 99) begin
                    bad++;
                    h = 0; l = 0;
                end
                qacc = qacc * 8 + (4 * h + l);
                ndig++;
                if (first_k < 0) first_k = k;
                last_k = k;
            end
            if (done) begin
                done_k = k;
                break;
            end
        end
        xbig   = 128'(xv) << (3 * (NDIG - 1));
        dbig   = 128'(dv);
        rem    = xbig - qacc * dbig;
        qfloor = xbig / dbig;
        qcorr  = qacc - ((rem < 0) ? 1 : 0);

        check(bad == 0, "R3", "illegal half-digit codes", bad, 0);
        check(ndig == NDIG, "R2", "digit count", ndig, NDIG);
        check(first_k == 1 && last_k == NDIG, "R2", "digit window end", last_k, NDIG);
        check(done_k == LAT, "R7", "done latency", done_k, LAT);
        check(rem >= -dbig && rem <= dbig, "R4", "remainder bound", rem, dbig);
        check(qcorr == qfloor, poke ? "R8" : "R5", "corrected quotient, operands captured (R1)",
              qcorr, qfloor);
        check(rem_neg == (rem < 0), "R6", "sign flag", rem_neg, (rem < 0));
        check(rem_zero == (rem == 0), "R6", "zero flag", rem_zero, (rem == 0));
        saved_neg  = rem_neg;
        saved_zero = rem_zero;
        @(negedge clk);
        check(done == 1'b0, "R7", "done single pulse", done, 0);
        @(negedge clk);
        check(rem_neg == saved_neg && rem_zero == saved_zero, "R7", "flags held",
              {rem_neg, rem_zero}, {saved_neg, saved_zero});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [OP_W-1:0] one_half, all_ones, three_q;
        void'($urandom(32'd4242));
        one_half = {1'b1, {(OP_W-1){1'b0}}};
        all_ones = '1;
        three_q  = {2'b11, {(OP_W-2){1'b0}}};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R9", "done after reset", done, 0);
        check(digit_valid == 1'b0, "R9", "digit_valid after reset", digit_valid, 0);

        run_div(one_half, one_half, 1'b0);
        run_div(all_ones, all_ones, 1'b0);
        run_div(one_half, all_ones, 1'b0);
        run_div(all_ones, one_half, 1'b0);
        run_div(three_q,  one_half, 1'b0);
        run_div(one_half, three_q,  1'b0);
        run_div(three_q,  three_q,  1'b1);
        run_div(all_ones, three_q,  1'b0);
        for (int i = 0; i < 40; i++)
            run_div(rand_norm(), rand_norm(), (i % 5) == 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule